// File: doc/BRIEF.md
# Self-Synchronous Byte Scrambler and Descrambler

This block whitens the user-data stream of a multi-gigabit converter link so that repetitive sample patterns do not concentrate energy into spectral lines. It holds two independent lanes: a transmit scrambler and a receive descrambler. Each lane takes one byte per clock cycle and handles its eight bits most significant first, all in that cycle. Each uses a 15-bit history of the scrambled stream and the polynomial 1 + x^14 + x^15.

The scrambler XORs every data bit with the scrambled bits sent 14 and 15 positions earlier. It then shifts its own output into the history. The descrambler applies the same XOR to the received bits and shifts the received scrambled bits into its history. Its state is therefore rebuilt from the line alone, and it locks onto the transmitter with no seed exchange. A per-lane enable bypasses the function: when it is low, bytes pass through unchanged and the history is frozen. Results appear one cycle after a valid input byte.

Top module: `ssc_pair`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both lanes drive out_valid low and out_data 0x00.
- R2: With the enable high, each valid transmit byte produces one cycle later out_valid high and a scrambled byte. Bits are taken MSB first (bit 7 first), and each scrambled bit is s[n] = d[n] XOR s[n-14] XOR s[n-15]. History bit i holds the scrambled bit from i+1 positions earlier, and reset loads the SEED parameter into it.
- R3: With the enable high, each valid receive byte produces one cycle later a byte whose bits are d[n] = s[n] XOR s[n-14] XOR s[n-15]. Here s is the received stream, and the received bits, not the outputs, enter the history.
- R4: When a valid byte arrives with the enable low, the lane outputs it unchanged one cycle later with out_valid high.
- R5: Bytes that pass with the enable low leave the history untouched, so later scrambled output is the same as if those bytes had never been sent.
- R6: A cycle with in_valid low gives out_valid low on the next cycle, holds out_data and does not advance the history.
- R7: Whatever its starting history, the descrambler output matches the original data from the 16th received bit onward. After a corrupted line bit it matches again from 16 bits later.
- R8: A receive lane fed the transmit output, with equal seeds and matching enables, returns the original data for every byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both lanes |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Scrambler enable; low passes data through |
| tx_in_valid | input | 1 | Transmit input byte is valid |
| tx_in_data | input | WIDTH | Transmit plain data byte |
| tx_out_valid | output | 1 | Transmit output byte is valid |
| tx_out_data | output | WIDTH | Scrambled (or bypassed) byte |
| rx_en | input | 1 | Descrambler enable; low passes data through |
| rx_in_valid | input | 1 | Receive input byte is valid |
| rx_in_data | input | WIDTH | Received scrambled byte |
| rx_out_valid | output | 1 | Receive output byte is valid |
| rx_out_data | output | WIDTH | Recovered (or bypassed) byte |

## Verification
A vector table mixes constant, alternating, all-ones and zero bytes with idle gaps and bypassed bytes. Repeating patterns show whether the output is really whitened and whether the bit order within a byte is correct. Idle and bypass entries show whether the history moves when it should not. Feeding the receive lane the scrambled stream checks the round trip. A mismatched starting history, and then a single flipped line bit, show whether the descrambler locks and relocks within the 15-bit window and no later. A replayed sequence with and without inserted bypass bytes separates a frozen history from one that drifts.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic {
        SSC_SCRAMBLE   = 1'b0,
        SSC_DESCRAMBLE = 1'b1
    } ssc_mode_e;

endpackage

// File: rtl/ssc_bitchain.sv
module ssc_bitchain
    import ssc_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter int        TAP_A = 14,
    parameter int        TAP_B = 15,
    parameter ssc_mode_e MODE  = SSC_SCRAMBLE
) (
    input  logic [TAP_B-1:0] hist_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o,
    output logic [TAP_B-1:0] hist_o
);
    localparam int HW = TAP_B;

    logic [HW-1:0] chain [0:WIDTH];

    assign chain[0] = hist_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int B = WIDTH - 1 - i;
        logic fb;
        logic res;
        logic shift_in;

        assign fb  = chain[i][TAP_A-1] ^ chain[i][TAP_B-1];
        assign res = data_i[B] ^ fb;

        if (MODE == SSC_SCRAMBLE) begin : g_scr
            assign shift_in = res;
        end else begin : g_dsc
            assign shift_in = data_i[B];
        end

        assign data_o[B]  = res;
        assign chain[i+1] = {chain[i][HW-2:0], shift_in};
    end

    assign hist_o = chain[WIDTH];

endmodule

// File: rtl/ssc_lane.sv
module ssc_lane
    import ssc_pkg::*;
#(
    parameter int           WIDTH = 8,
    parameter int           TAP_A = 14,
    parameter int           TAP_B = 15,
    parameter logic [TAP_B-1:0] SEED = 15'h4A5B,
    parameter ssc_mode_e    MODE  = SSC_SCRAMBLE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    localparam int HW = TAP_B;

    typedef struct packed {
        logic [HW-1:0]    hist;
        logic             vld;
        logic [WIDTH-1:0] data;
    } lane_s;

    lane_s st_d, st_q;
    logic [WIDTH-1:0] chain_data;
    logic [HW-1:0]    chain_hist;

    ssc_bitchain #(
        .WIDTH (WIDTH),
        .TAP_A (TAP_A),
        .TAP_B (TAP_B),
        .MODE  (MODE)
    ) chain_i (
        .hist_i (st_q.hist),
        .data_i (in_data),
        .data_o (chain_data),
        .hist_o (chain_hist)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (en) begin
                st_d.data = chain_data;
                st_d.hist = chain_hist;
            end else begin
                st_d.data = in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hist <= SEED;
            st_q.vld  <= 1'b0;
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.hist));
    p_idle_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    p_bypass_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.hist));
    p_bypass_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en) |=> (out_data == $past(in_data)));

endmodule

// File: rtl/ssc_pair.sv
module ssc_pair
    import ssc_pkg::*;
#(
    parameter int               WIDTH   = 8,
    parameter int               TAP_A   = 14,
    parameter int               TAP_B   = 15,
    parameter logic [TAP_B-1:0] TX_SEED = 15'h4A5B,
    parameter logic [TAP_B-1:0] RX_SEED = 15'h4A5B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_in_valid,
    input  logic [WIDTH-1:0] tx_in_data,
    output logic             tx_out_valid,
    output logic [WIDTH-1:0] tx_out_data,
    input  logic             rx_en,
    input  logic             rx_in_valid,
    input  logic [WIDTH-1:0] rx_in_data,
    output logic             rx_out_valid,
    output logic [WIDTH-1:0] rx_out_data
);

    ssc_lane #(
        .WIDTH (WIDTH), .TAP_A (TAP_A), .TAP_B (TAP_B),
        .SEED  (TX_SEED), .MODE (SSC_SCRAMBLE)
    ) tx_lane_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .in_valid  (tx_in_valid),
        .in_data   (tx_in_data),
        .out_valid (tx_out_valid),
        .out_data  (tx_out_data)
    );

    ssc_lane #(
        .WIDTH (WIDTH), .TAP_A (TAP_A), .TAP_B (TAP_B),
        .SEED  (RX_SEED), .MODE (SSC_DESCRAMBLE)
    ) rx_lane_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .in_valid  (rx_in_valid),
        .in_data   (rx_in_data),
        .out_valid (rx_out_valid),
        .out_data  (rx_out_data)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!tx_out_valid && !rx_out_valid && tx_out_data == '0 && rx_out_data == '0));

endmodule

// File: tb/ssc_pair_tb_top.sv
module ssc_pair_tb_top;
    localparam logic [14:0] SEED     = 15'h4A5B;
    localparam logic [14:0] ALT_SEED = 15'h1357;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_in_valid = 1'b0;
    logic [7:0] tx_in_data = '0;
    logic       tx_out_valid;
    logic [7:0] tx_out_data;
    logic       rx_en = 1'b0, rx_in_valid = 1'b0;
    logic [7:0] rx_in_data = '0;
    logic       rx_out_valid;
    logic [7:0] rx_out_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ssc_pair #(.TX_SEED(SEED), .RX_SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_en(tx_en), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .rx_en(rx_en), .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
    );

    // {en, valid, data}
    localparam logic [9:0] VEC [16] = '{
        {2'b11, 8'h00}, {2'b11, 8'h00}, {2'b11, 8'hFF}, {2'b11, 8'hAA},
        {2'b01, 8'h5C}, {2'b11, 8'h55}, {2'b10, 8'h77}, {2'b11, 8'h80},
        {2'b11, 8'h01}, {2'b01, 8'hFF}, {2'b01, 8'h00}, {2'b11, 8'h3C},
        {2'b00, 8'h12}, {2'b11, 8'hC3}, {2'b11, 8'h00}, {2'b11, 8'hE7}
    };

    // returns {new history, output byte}; history bit i = stream bit i+1 back
    function automatic logic [22:0] mstep(input logic [14:0] h, input logic [7:0] d,
                                          input bit scr);
        logic [7:0] o;
        for (int k = 7; k >= 0; k--) begin
            o[k] = d[k] ^ h[13] ^ h[14];
            h    = {h[13:0], scr ? o[k] : d[k]};
        end
        return {h, o};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_en = 0; tx_in_valid = 0; tx_in_data = '0;
        rx_en = 0; rx_in_valid = 0; rx_in_data = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic te, input logic tv, input logic [7:0] td,
                         input logic re, input logic rv, input logic [7:0] rd);
        tx_en = te; tx_in_valid = tv; tx_in_data = td;
        rx_en = re; rx_in_valid = rv; rx_in_data = rd;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [14:0] th, rh;
        logic [22:0] r;
        logic [7:0]  sv, prev_tx, prev_rx, q1, q2;
        logic [7:0]  line [8];
        logic [7:0]  orig [8];

        // R1 reset state
        #1;
        @(negedge clk);
        check("R1 tx_valid", {7'd0, tx_out_valid}, 8'h00);
        check("R1 tx_data", tx_out_data, 8'h00);
        check("R1 rx_valid", {7'd0, rx_out_valid}, 8'h00);
        check("R1 rx_data", rx_out_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {6'd0, tx_out_valid, rx_out_valid}, 8'h00);

        // vector table: tx scrambles, rx gets the line bytes (R2 R3 R4 R6 R8)
        th = SEED; prev_tx = 8'h00; prev_rx = 8'h00;
        for (int i = 0; i < 16; i++) begin
            logic e, v;
            logic [7:0] d;
            {e, v, d} = VEC[i];
            sv = d;
            if (v && e) begin
                r = mstep(th, d, 1'b1);
                th = r[22:8]; sv = r[7:0];
            end
            drive(e, v, d, e, v, sv);
            check("R6 tx valid", {7'd0, tx_out_valid}, {7'd0, v});
            check("R6 rx valid", {7'd0, rx_out_valid}, {7'd0, v});
            if (v) begin
                check(e ? "R2 scramble" : "R4 tx bypass", tx_out_data, sv);
                check(e ? "R8 round trip" : "R4 rx bypass", rx_out_data, d);
                prev_tx = sv; prev_rx = d;
            end else begin
                check("R6 tx hold", tx_out_data, prev_tx);
                check("R6 rx hold", rx_out_data, prev_rx);
            end
        end

        // R3 descramble alone against model with an arbitrary line stream
        do_reset();
        rh = SEED;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] ln;
            ln = 8'h96 + 8'(i * 37);
            r = mstep(rh, ln, 1'b0);
            rh = r[22:8];
            drive(0, 0, 0, 1, 1, ln);
            check("R3 descramble", rx_out_data, r[7:0]);
        end

        // R5 bypass bytes leave history unchanged
        do_reset();
        drive(1, 1, 8'h3A, 0, 0, 0);
        drive(1, 1, 8'hC5, 0, 0, 0);
        q1 = tx_out_data;
        do_reset();
        drive(1, 1, 8'h3A, 0, 0, 0);
        drive(0, 1, 8'hFF, 0, 0, 0);
        drive(0, 1, 8'h0F, 0, 0, 0);
        drive(0, 0, 8'h00, 0, 0, 0);
        drive(1, 1, 8'hC5, 0, 0, 0);
        q2 = tx_out_data;
        check("R5 frozen history", q2, q1);

        // R7 self-sync: line made with a different history than the rx seed
        do_reset();
        th = ALT_SEED;
        for (int i = 0; i < 8; i++) begin
            orig[i] = 8'h21 * 8'(i + 3);
            r = mstep(th, orig[i], 1'b1);
            th = r[22:8]; line[i] = r[7:0];
        end
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, 0, 1, 1, line[i]);
            if (i == 1) check("R7 bit16", {7'd0, rx_out_data[0]}, {7'd0, orig[i][0]});
            if (i >= 2) check("R7 locked", rx_out_data, orig[i]);
        end

        // R7 relock after one flipped line bit in byte 2
        do_reset();
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, 0, 1, 1, (i == 2) ? (line[i] ^ 8'h10) : line[i]);
            if (i >= 5) check("R7 relock", rx_out_data, orig[i]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule